// File: doc/BRIEF.md
# Timer Software Event Generator

A 16-bit timer core that lets software force events without waiting for the counter. A write to the event register can fire four kinds of event. An update event restarts the count. A trigger event raises a trigger flag. A channel event acts on one of four capture/compare channels. Each event bit acts in the cycle of the write and then clears itself, so the register always reads back as zero.

The core holds the following state:
- the counter and its prescaler;
- an auto-reload limit;
- four channel value registers;
- a status word of event and overcapture flags.

Status flags combine with per-source enable bits to drive one interrupt line and one DMA request line per source. Counting runs up, down or center-aligned. A forced update restarts the count in the way that matches the counting direction. A forced channel event in input mode copies the live count, as a capture would.

Registers are 16 bits wide on a 32-bit bus with byte strobes. Half-word and word accesses behave the same, because only the low two byte lanes carry register data. Word addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | bit0 run, bits2:1 mode (0 up, 1 down, 2 or 3 center) |
| 1 | INTEN | bit k interrupt enable, bit 8+k DMA enable, for status bit k |
| 2 | STATUS | flags |
| 3 | EVENT | write-only event bits |
| 4 | CHIN | bit n set means channel n is an input |
| 5 | COUNT | counter value |
| 6 | PSC | prescaler limit |
| 7 | ARR | reload limit, resets to 0xFFFF |
| 8 to 11 | CCV0 to CCV3 | channel value registers |

Top module: `timer_swevt`

## Requirements
- R1: EVENT (address 3) always reads as zero. An event bit acts only in the cycle of its write, and later cycles do not repeat its effect.
- R2: Event bits 5 and 7 to 15 are reserved, and writing ones to them changes neither the counter nor STATUS.
- R3: A forced update (EVENT bit 0) sets COUNT to 0 in up mode and in center mode. In down mode it loads COUNT with ARR.
- R4: A forced update clears the prescaler count, so with PSC = p the next counter step comes p+1 cycles after the write.
- R5: A forced update sets STATUS bit 0.
- R6: A forced trigger (EVENT bit 6) sets STATUS bit 6.
- R7: A forced event on channel n (EVENT bit 1+n) sets STATUS bit 1+n.
- R8: A forced event on channel n while CHIN bit n is set copies the current COUNT into CCVn.
- R9: A forced event on an input channel n whose STATUS bit 1+n is already set also sets the overcapture bit, STATUS bit 9+n.
- R10: A forced event on channel n while CHIN bit n is clear leaves CCVn unchanged and sets no overcapture bit.
- R11: irq_o is high while any STATUS bit k in {0..4, 6} is set together with INTEN bit k. dma_req_o is indexed [0] update, [1+n] channel n, [5] trigger. Each dma_req_o bit is the source flag ANDed with INTEN bit 8+k.
- R12: Writing STATUS clears each flag whose written bit is 0 and leaves each flag whose written bit is 1.
- R13: A write acts on the byte lanes enabled by strobe bits 1:0, so strobe 0011 and 1111 act the same. A write with strobe 1100 has no effect. Read data bits 31:16 are zero.
- R14: While CTRL bit 0 is set, the counter steps once every PSC+1 cycles. In up mode it wraps from ARR to 0, and that wrap sets STATUS bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_strb_i | input | 4 | Byte lane strobes |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Combined interrupt request |
| dma_req_o | output | 6 | Per-source DMA requests |

## Verification
The forced update is applied with the counter parked at a mid-range value in each of the three counting modes. Clear-to-zero and load-from-ARR give different results, so an error in the direction choice shows up. The prescaler clear is timed against a prescaler that has been left mid-count, where a missing clear would make the counter step early. Forced channel events are applied:
- twice to an input channel, with different counts, which separates capture from no capture and first capture from overcapture;
- once to an output channel whose value is known.

Reserved bits, strobe patterns and status write-zero patterns are each chosen so that an ignored write differs visibly from an accepted one.

// File: rtl/timer_swevt_pkg.sv
package timer_swevt_pkg;
  localparam int REG_W = 16;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    CNT_UP     = 2'd0,
    CNT_DOWN   = 2'd1,
    CNT_CENTER = 2'd2,
    CNT_CENTR2 = 2'd3
  } cnt_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_INTEN = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_EVT   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CHIN  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'd5;
  localparam logic [ADDR_W-1:0] A_PSC   = 4'd6;
  localparam logic [ADDR_W-1:0] A_ARR   = 4'd7;
  localparam logic [ADDR_W-1:0] A_CCV0  = 4'd8;

  function automatic logic [REG_W-1:0] lane_mask(input logic [1:0] strb);
    return {{8{strb[1]}}, {8{strb[0]}}};
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic [W-1:0] psc_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = run_i && !clr_i && (cnt_q >= psc_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i) begin
      if (cnt_q >= psc_i)     cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import timer_swevt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  cnt_mode_e    mode_i,
  input  logic [W-1:0] arr_i,
  input  logic         force_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         down_q;  // center mode phase
  logic         at_top, at_bot, step;

  assign at_top = cnt_q >= arr_i;
  assign at_bot = cnt_q == '0;
  assign step   = tick_i && !force_i && !wr_i;
  assign cnt_o  = cnt_q;

  always_comb begin
    unique case (mode_i)
      CNT_UP:   wrap_o = step && at_top;
      CNT_DOWN: wrap_o = step && at_bot;
      default:  wrap_o = step && (down_q ? at_bot : at_top);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (force_i) begin
      cnt_q  <= (mode_i == CNT_DOWN) ? arr_i : '0;
      down_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q  <= wdata_i;
    end else if (tick_i) begin
      unique case (mode_i)
        CNT_UP:   cnt_q <= at_top ? '0 : cnt_q + 1'b1;
        CNT_DOWN: cnt_q <= at_bot ? arr_i : cnt_q - 1'b1;
        default: begin
          if (!down_q) begin
            if (at_top) begin
              down_q <= 1'b1;
              cnt_q  <= at_bot ? '0 : cnt_q - 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end else begin
            if (at_bot) begin
              down_q <= 1'b0;
              cnt_q  <= cnt_q + 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         is_input_i,
  input  logic [W-1:0] cnt_i,
  input  logic         ccv_we_i,
  input  logic [W-1:0] ccv_wdata_i,
  input  logic         flag_clr_i,
  input  logic         ofl_clr_i,
  output logic [W-1:0] ccv_o,
  output logic         flag_o,
  output logic         ofl_o
);
  logic [W-1:0] ccv_q;
  logic         flag_q, ofl_q;
  logic         capture;

  assign capture = evt_i && is_input_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccv_q  <= '0;
      flag_q <= 1'b0;
      ofl_q  <= 1'b0;
    end else begin
      if (capture)         ccv_q <= cnt_i;
      else if (ccv_we_i)   ccv_q <= ccv_wdata_i;
      if (evt_i)           flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (capture && flag_q) ofl_q <= 1'b1;
      else if (ofl_clr_i)    ofl_q <= 1'b0;
    end
  end

  assign ccv_o  = ccv_q;
  assign flag_o = flag_q;
  assign ofl_o  = ofl_q;
endmodule

// File: rtl/timer_swevt.sv
module timer_swevt
  import timer_swevt_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  input  logic [3:0]        bus_strb_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic [NCH+1:0]    dma_req_o
);
  localparam int W        = REG_W;
  localparam int TRG_BIT  = NCH + 2;
  localparam int OFL_BASE = TRG_BIT + 3;

  logic [W-1:0] lmask, wd, evt_bits, stat_clr, stat;
  logic         wr_hit;
  logic         evt_upd, evt_trg;
  logic [NCH-1:0] evt_ch;

  logic [2:0]     ctrl_q;
  logic [W-1:0]   inten_q, psc_q, arr_q;
  logic [NCH-1:0] chin_q;
  logic           upd_f, trg_f;

  logic [W-1:0]   cnt, psc_cnt;
  logic           tick, wrap;
  cnt_mode_e      mode;
  logic [NCH-1:0] chf, ofl, ccv_we;
  logic [W-1:0]   ccv [NCH];
  logic [NCH*W-1:0] ccv_flat;

  assign wr_hit = bus_we_i && (|bus_strb_i[1:0]);
  assign lmask  = lane_mask(bus_strb_i[1:0]);
  assign wd     = bus_wdata_i[W-1:0];

  function automatic logic [W-1:0] merge(input logic [W-1:0] old);
    return (old & ~lmask) | (wd & lmask);
  endfunction

  // events act in the write cycle only; nothing is stored
  assign evt_bits = (wr_hit && bus_addr_i == A_EVT) ? (wd & lmask) : '0;
  assign evt_upd  = evt_bits[0];
  assign evt_ch   = evt_bits[NCH:1];
  assign evt_trg  = evt_bits[TRG_BIT];
  assign stat_clr = (wr_hit && bus_addr_i == A_STAT) ? (~wd & lmask) : '0;
  assign mode     = cnt_mode_e'(ctrl_q[2:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      inten_q <= '0;
      chin_q  <= '0;
      psc_q   <= '0;
      arr_q   <= '1;
    end else if (wr_hit) begin
      unique case (bus_addr_i)
        A_CTRL:  ctrl_q  <= merge({13'b0, ctrl_q})[2:0];
        A_INTEN: inten_q <= merge(inten_q);
        A_CHIN:  chin_q  <= merge({{(W-NCH){1'b0}}, chin_q})[NCH-1:0];
        A_PSC:   psc_q   <= merge(psc_q);
        A_ARR:   arr_q   <= merge(arr_q);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_f <= 1'b0;
      trg_f <= 1'b0;
    end else begin
      if (evt_upd || wrap)         upd_f <= 1'b1;
      else if (stat_clr[0])        upd_f <= 1'b0;
      if (evt_trg)                 trg_f <= 1'b1;
      else if (stat_clr[TRG_BIT])  trg_f <= 1'b0;
    end
  end

  tmr_prescaler #(.W(W)) u_psc (
    .clk_i, .rst_ni,
    .run_i  (ctrl_q[0]),
    .clr_i  (evt_upd),
    .psc_i  (psc_q),
    .cnt_o  (psc_cnt),
    .tick_o (tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i  (tick),
    .mode_i  (mode),
    .arr_i   (arr_q),
    .force_i (evt_upd),
    .wr_i    (wr_hit && bus_addr_i == A_CNT),
    .wdata_i (merge(cnt)),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ccv_we[i] = wr_hit && (bus_addr_i == ADDR_W'(A_CCV0 + i));
    tmr_channel #(.W(W)) u_ch (
      .clk_i, .rst_ni,
      .evt_i       (evt_ch[i]),
      .is_input_i  (chin_q[i]),
      .cnt_i       (cnt),
      .ccv_we_i    (ccv_we[i]),
      .ccv_wdata_i (merge(ccv[i])),
      .flag_clr_i  (stat_clr[1+i]),
      .ofl_clr_i   (stat_clr[OFL_BASE+i]),
      .ccv_o       (ccv[i]),
      .flag_o      (chf[i]),
      .ofl_o       (ofl[i])
    );
    assign ccv_flat[i*W +: W] = ccv[i];
  end

  always_comb begin
    stat                   = '0;
    stat[0]                = upd_f;
    stat[NCH:1]            = chf;
    stat[TRG_BIT]          = trg_f;
    stat[OFL_BASE +: NCH]  = ofl;
  end

  assign irq_o     = |(stat[7:0] & inten_q[7:0]);
  assign dma_req_o = {trg_f & inten_q[8+TRG_BIT], chf & inten_q[8+NCH:9], upd_f & inten_q[8]};

  logic [W-1:0] rd;
  always_comb begin
    rd = '0;
    unique case (bus_addr_i)
      A_CTRL:  rd = {13'b0, ctrl_q};
      A_INTEN: rd = inten_q;
      A_STAT:  rd = stat;
      A_CHIN:  rd[NCH-1:0] = chin_q;
      A_CNT:   rd = cnt;
      A_PSC:   rd = psc_q;
      A_ARR:   rd = arr_q;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (bus_addr_i == ADDR_W'(A_CCV0 + i)) rd = ccv[i];
      end
    endcase
  end
  assign bus_rdata_o = {{(BUS_W-W){1'b0}}, rd};

  logic unused_bits;
  assign unused_bits = ^{bus_wdata_i[BUS_W-1:W], bus_strb_i[3:2], inten_q[W-1:8+TRG_BIT+1],
                         inten_q[8+NCH+1], inten_q[8+TRG_BIT-1:8+NCH+1], ccv_flat, psc_cnt};
endmodule

// File: rtl/tmr_swevt_chk.sv
module tmr_swevt_chk #(
  parameter int W   = 16,
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           evt_upd,
  input logic [NCH-1:0] evt_ch,
  input logic           evt_trg,
  input logic [1:0]     mode,
  input logic [NCH-1:0] chin,
  input logic [W-1:0]   cnt,
  input logic [W-1:0]   arr,
  input logic [W-1:0]   psc_cnt,
  input logic [NCH-1:0] chf,
  input logic [NCH-1:0] ofl,
  input logic           upd_f,
  input logic           trg_f,
  input logic [NCH*W-1:0] ccv_flat,
  input logic [3:0]     addr,
  input logic [31:0]    rdata
);
  AST_EVT_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == 4'd3) |-> (rdata == 32'd0));  // R1
  AST_UPD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_upd && mode != 2'd1) |=> (cnt == '0));  // R3
  AST_UPD_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_upd && mode == 2'd1) |=> (cnt == $past(arr)));  // R3
  AST_PSC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_upd |=> (psc_cnt == '0));  // R4
  AST_UPD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_upd |=> upd_f);  // R5
  AST_TRG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_trg |=> trg_f);  // R6

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_CH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_ch[i] |=> chf[i]);  // R7
    AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_ch[i] && chin[i]) |=> (ccv_flat[i*W +: W] == $past(cnt)));  // R8
    AST_OVERCAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_ch[i] && chin[i] && chf[i]) |=> ofl[i]);  // R9
    AST_OUTPUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_ch[i] && !chin[i]) |=> $stable(ccv_flat[i*W +: W]));  // R10
  end
endmodule

bind timer_swevt tmr_swevt_chk #(.W(16), .NCH(NCH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_upd  (evt_upd),
  .evt_ch   (evt_ch),
  .evt_trg  (evt_trg),
  .mode     (ctrl_q[2:1]),
  .chin     (chin_q),
  .cnt      (cnt),
  .arr      (arr_q),
  .psc_cnt  (psc_cnt),
  .chf      (chf),
  .ofl      (ofl),
  .upd_f    (upd_f),
  .trg_f    (trg_f),
  .ccv_flat (ccv_flat),
  .addr     (bus_addr_i),
  .rdata    (bus_rdata_o)
);

// File: tb/timer_swevt_test.sv
module timer_swevt_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [3:0]  bus_strb_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;
  logic [5:0]  dma_req_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  timer_swevt uut (.*);

  localparam logic [3:0] CTRL = 0, INTEN = 1, STAT = 2, EVT = 3, CHIN = 4,
                         CNT = 5, PSC = 6, ARR = 7, CCV1 = 9, CCV2 = 10;

  typedef struct {
    int          sel;   // 0 read data, 1 irq, 2 dma
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic  rd_pending = 1'b0;
  int    n_chk = 0, n_bad = 0;
  bit    done = 0;

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(posedge clk_i); #1;
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; bus_strb_i = s;
    @(posedge clk_i); #1;
    bus_we_i = 1'b0; bus_strb_i = '0;
  endtask

  task automatic expect_item(input int sel, input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk_i); #1;
    bus_addr_i = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    rd_pending = 1'b1;
    @(negedge clk_i); #1;
    rd_pending = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    expect_item(0, a, e, tag);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rd_pending && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.sel == 0) ? bus_rdata_o : (it.sel == 1) ? {31'b0, irq_o} : {26'b0, dma_req_o};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk(STAT, 32'h0, "reset status R12");
    chk(CNT, 32'h0, "reset count R14");
    chk(ARR, 32'h0000_FFFF, "reset arr R13");

    // forced update, up mode
    wr(ARR, 100); wr(COUNT_A(), 37); wr(CTRL, 0); wr(EVT, 1);
    chk(CNT, 0, "R3 up clear");
    chk(STAT, 32'h1, "R5 update flag");
    chk(EVT, 0, "R1 event reads zero");
    wr(STAT, 0); wr(CNT, 5);
    repeat (3) @(posedge clk_i);
    chk(CNT, 5, "R1 no repeat");
    chk(STAT, 0, "R1 flag not re-set");

    // down mode reload
    wr(CTRL, 2); wr(CNT, 37); wr(EVT, 1);
    chk(CNT, 100, "R3 down reload");
    // center mode
    wr(CTRL, 4); wr(CNT, 37); wr(EVT, 1);
    chk(CNT, 0, "R3 center clear");
    wr(STAT, 0);

    // strobes
    wr(CTRL, 2); wr(CNT, 37); wr(EVT, 1, 4'b1100);
    chk(CNT, 37, "R13 upper lanes ignored");
    chk(STAT, 0, "R13 upper lanes no flag");
    wr(EVT, 1, 4'b0011);
    chk(CNT, 100, "R13 half-word acts");
    chk(ARR, 32'h0000_0064, "R13 upper read zero");
    wr(STAT, 0);

    // reserved bits
    wr(CNT, 37); wr(EVT, 32'h0000_FFA0);
    chk(CNT, 37, "R2 reserved count");
    chk(STAT, 0, "R2 reserved status");

    // capture / overcapture
    wr(CHIN, 4'b0100); wr(CNT, 16'h1234); wr(EVT, 1 << 3);
    chk(CCV2, 16'h1234, "R8 capture");
    chk(STAT, 32'h0008, "R7 channel flag");
    wr(CNT, 16'h2222); wr(EVT, 1 << 3);
    chk(CCV2, 16'h2222, "R8 second capture");
    chk(STAT, 32'h0808, "R9 overcapture");

    // output mode channel
    wr(CCV1, 16'h0AAA); wr(EVT, 1 << 2);
    chk(CCV1, 16'h0AAA, "R10 output hold");
    chk(STAT, 32'h080C, "R10 flag no overcapture");

    // status write-zero clear
    wr(STAT, 32'h0000_FFFB);
    chk(STAT, 32'h0808, "R12 selective clear");
    wr(STAT, 0);
    chk(STAT, 0, "R12 full clear");

    // trigger and irq
    wr(INTEN, 1 << 6);
    expect_item(1, STAT, 0, "R11 irq idle");
    wr(EVT, 1 << 6);
    chk(STAT, 32'h0040, "R6 trigger flag");
    expect_item(1, STAT, 1, "R11 irq trigger");
    wr(STAT, 0);
    expect_item(1, STAT, 0, "R11 irq cleared");

    // dma
    wr(INTEN, 1 << 9); wr(EVT, 1 << 1);
    expect_item(2, STAT, 32'h02, "R11 dma ch0");
    expect_item(1, STAT, 0, "R11 irq not enabled");
    wr(STAT, 0);

    // free counting
    wr(CTRL, 0); wr(ARR, 3); wr(PSC, 1); wr(CNT, 0); wr(STAT, 0);
    wr(CTRL, 1);
    repeat (5) @(posedge clk_i);
    chk(CNT, 3, "R14 count step");
    repeat (1) @(posedge clk_i);
    chk(CNT, 0, "R14 wrap");
    chk(STAT, 32'h1, "R14 wrap flag");

    // prescaler clear
    wr(CTRL, 0); wr(PSC, 9); wr(ARR, 100); wr(CTRL, 1);
    repeat (4) @(posedge clk_i);
    wr(EVT, 1);
    repeat (8) @(posedge clk_i);
    chk(CNT, 0, "R4 no early step");
    chk(CNT, 1, "R4 step after psc+1");

    repeat (2) @(posedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [3:0] COUNT_A();
    return CNT;
  endfunction
endmodule